// File: doc/BRIEF.md
# Four-Wire Display SPI Command Engine

This block is an SPI master for small display controllers that take a separate data/command select line. A request carries one command byte and a byte count. The engine pulls chip select low and shifts the command out with the select line low. It then either streams the parameter or pixel bytes with the select line high, or clocks in reply bytes when the command is a register read. Bytes are moved in SPI mode 0, most significant bit first. The serial clock rate is chosen for each phase: a capped rate for the command byte and short parameter bursts, the full rate for long pixel bursts, and a slow rate for reads.

Two identity and status queries on the display return their data one clock late. For these the engine clocks one extra byte and realigns the reply before passing it on. When a power-mode reply comes back, the engine also judges whether the panel is already on.

Top module: `dspi_engine`

## Requirements
- R1: The command byte is shifted first, with `csN` low and `dc` = 0. `mosi` changes only while `sclk` is low (mode 0, `sclk` idles low), and bits go out MSB first.
- R2: For a command that is not on the read list, `reqLen` parameter bytes follow the command byte with `dc` = 1. Each byte is taken from `parData`, which must be valid in the cycle `parTake` is high; there is one `parTake` pulse per byte.
- R3: `csN` stays low from the command byte through the last data byte, and `busy` is high for that whole span. Afterwards `csN` returns high and `done` pulses for one cycle while `busy` is low.
- R4: The command byte, and write bursts of at most `LONG_MIN` bytes, use an `sclk` half-period of `CMD_HALF` clocks. Write bursts longer than `LONG_MIN` use `FAST_HALF` clocks.
- R5: A command on the read list (0x04, 0x06–0x0F, 0x2E, 0x3E, 0x45, 0x52, 0x54, 0x56, 0x5F, 0xA1, 0xA8) clocks its reply bytes with `mosi` = 0, `dc` = 0 and a half-period of `READ_HALF` clocks. Each byte is sampled from `miso` on the rising edge of `sclk` and returned on `rdData` with a one-cycle `rdValid`.
- R6: For commands 0x04 and 0x09, `reqLen` + 1 bytes are clocked. Result byte i equals received byte i shifted left by one, with bit 0 taken from bit 7 of received byte i+1.
- R7: A request for 0x04 or 0x09 with a length other than 3 or 4 sets `err` and pulses `done` without lowering `csN` or toggling `sclk`. `err` holds until the next accepted request.
- R8: After a read of command 0x0A, `panelOn` = 1 exactly when the first reply byte, with bits 7, 1 and 0 cleared, equals 0x1C (bits 4, 3 and 2 set). The value holds until the next 0x0A read.
- R9: With `reqLen` = 0, only the command byte is clocked.
- R10: After reset, `csN` = 1, `sclk` = 0, `dc` = 0, and `busy`, `done`, `err` and `panelOn` are all 0.
- R11: A `reqValid` raised while `busy` is high is ignored. The running transfer continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Start a transaction (taken when idle) |
| reqCmd | input | 8 | Command byte |
| reqLen | input | CNT_W | Number of parameter or reply bytes |
| parData | input | 8 | Next parameter or pixel byte |
| parTake | output | 1 | `parData` is consumed at this clock edge |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | Illegal reply length was requested |
| rdValid | output | 1 | `rdData` holds a reply byte |
| rdData | output | 8 | Reply byte |
| panelOn | output | 1 | Last power-mode reply showed the panel on |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 1 | Chip select, active low |
| dc | output | 1 | Data/command select, 1 = data |

## Verification
Two events can land in the same cycle. The first is the shifter's end-of-byte strobe for the final reply byte. The second is the emission of a realigned result: on dummy-clock reads the last result is released by the byte-done of the extra byte, and the same cycle moves the controller to close chip select. The bench provokes this with 3- and 4-byte dummy reads whose reply bit patterns carry across byte borders. It judges the outcome by the count and values of the returned bytes and by the absence of any cycle with chip select low and `busy` low. A second overlap, a new request arriving mid-transfer, is driven directly, and the bench checks that the serial log is unchanged.

// File: rtl/dspi_pkg.sv
package dspi_pkg;

  typedef enum logic [1:0] {RATE_FAST, RATE_CMD, RATE_READ} rate_e;

  typedef struct packed {
    logic  load;
    rate_e rate;
  } dspi_strobe_t;

  function automatic logic isReadCmd(input logic [7:0] c);
    case (c)
      8'h04, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D,
      8'h0E, 8'h0F, 8'h2E, 8'h3E, 8'h45, 8'h52, 8'h54, 8'h56, 8'h5F,
      8'hA1, 8'hA8: isReadCmd = 1'b1;
      default:      isReadCmd = 1'b0;
    endcase
  endfunction

  function automatic logic hasDummyClk(input logic [7:0] c);
    hasDummyClk = (c == 8'h04) || (c == 8'h09);
  endfunction

endpackage

// File: rtl/dspi_shifter.sv
module dspi_shifter
  import dspi_pkg::*;
#(
  parameter int FAST_HALF = 1,
  parameter int CMD_HALF  = 2,
  parameter int READ_HALF = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  dspi_strobe_t strb,
  input  logic [7:0]   txByte,
  input  logic         miso,
  output logic         sclk,
  output logic         mosi,
  output logic         byteDone,
  output logic [7:0]   rxByte
);
  localparam int MAX_AB = (FAST_HALF > CMD_HALF) ? FAST_HALF : CMD_HALF;
  localparam int MAX_H  = (MAX_AB > READ_HALF) ? MAX_AB : READ_HALF;
  localparam int HW     = $clog2(MAX_H + 1);

  logic [7:0]    shReg;
  logic [7:0]    rxReg;
  logic [2:0]    bitCnt;
  logic [HW-1:0] halfCnt;
  logic [HW-1:0] halfLim;
  logic          active;

  function automatic logic [HW-1:0] limFor(input rate_e r);
    case (r)
      RATE_FAST: limFor = HW'(FAST_HALF);
      RATE_READ: limFor = HW'(READ_HALF);
      default:   limFor = HW'(CMD_HALF);
    endcase
  endfunction

  assign mosi   = shReg[7];
  assign rxByte = rxReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      rxReg    <= '0;
      bitCnt   <= '0;
      halfCnt  <= '0;
      halfLim  <= HW'(CMD_HALF);
      active   <= 1'b0;
      sclk     <= 1'b0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (strb.load) begin
        shReg   <= txByte;
        active  <= 1'b1;
        halfCnt <= '0;
        bitCnt  <= '0;
        sclk    <= 1'b0;
        halfLim <= limFor(strb.rate);
      end else if (active) begin
        if (halfCnt == halfLim - HW'(1)) begin
          halfCnt <= '0;
          sclk    <= ~sclk;
          if (!sclk) begin
            rxReg <= {rxReg[6:0], miso};
          end else if (bitCnt == 3'd7) begin
            active   <= 1'b0;
            byteDone <= 1'b1;
          end else begin
            bitCnt <= bitCnt + 3'd1;
            shReg  <= {shReg[6:0], 1'b0};
          end
        end else begin
          halfCnt <= halfCnt + HW'(1);
        end
      end
    end
  end

  // R1
  load_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> !active);

endmodule

// File: rtl/dspi_ctrl.sv
module dspi_ctrl
  import dspi_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int LONG_MIN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [7:0]       reqCmd,
  input  logic [CNT_W-1:0] reqLen,
  input  logic [7:0]       parData,
  input  logic             byteDone,
  input  logic [7:0]       rxByte,
  output dspi_strobe_t     strb,
  output logic [7:0]       txByte,
  output logic             parTake,
  output logic             csN,
  output logic             dc,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             rdValid,
  output logic [7:0]       rdData,
  output logic             panelOn
);
  typedef enum logic [2:0] {ST_IDLE, ST_CMD, ST_WRITE, ST_READ, ST_FINISH} state_e;
  typedef enum logic [1:0] {TX_CMD, TX_PAR, TX_ZERO} kind_e;

  state_e         state;
  kind_e          kind;
  logic           load;
  rate_e          rate;
  logic [7:0]     cmdReg;
  logic [CNT_W:0] remaining;
  logic           isRd;
  logic           isDummy;
  logic           longBurst;
  logic           firstRx;
  logic [7:0]     prevRx;

  always_comb begin
    strb.load = load;
    strb.rate = rate;
    case (kind)
      TX_CMD:  txByte = cmdReg;
      TX_PAR:  txByte = parData;
      default: txByte = 8'h00;
    endcase
  end

  assign parTake = load && (kind == TX_PAR);
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= TX_CMD;
      load      <= 1'b0;
      rate      <= RATE_CMD;
      cmdReg    <= '0;
      remaining <= '0;
      isRd      <= 1'b0;
      isDummy   <= 1'b0;
      longBurst <= 1'b0;
      firstRx   <= 1'b0;
      prevRx    <= '0;
      csN       <= 1'b1;
      dc        <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      rdValid   <= 1'b0;
      rdData    <= '0;
      panelOn   <= 1'b0;
    end else begin
      load    <= 1'b0;
      done    <= 1'b0;
      rdValid <= 1'b0;
      case (state)
        ST_IDLE: if (reqValid) begin
          if (hasDummyClk(reqCmd) && (reqLen != CNT_W'(3)) && (reqLen != CNT_W'(4))) begin
            err  <= 1'b1;
            done <= 1'b1;
          end else begin
            err       <= 1'b0;
            cmdReg    <= reqCmd;
            isRd      <= isReadCmd(reqCmd);
            isDummy   <= hasDummyClk(reqCmd);
            longBurst <= reqLen > CNT_W'(LONG_MIN);
            remaining <= {1'b0, reqLen} + (CNT_W+1)'(hasDummyClk(reqCmd));
            csN       <= 1'b0;
            dc        <= 1'b0;
            kind      <= TX_CMD;
            rate      <= RATE_CMD;
            load      <= 1'b1;
            state     <= ST_CMD;
          end
        end
        ST_CMD: if (byteDone) begin
          if (remaining == '0) begin
            state <= ST_FINISH;
          end else if (isRd) begin
            kind    <= TX_ZERO;
            rate    <= RATE_READ;
            load    <= 1'b1;
            firstRx <= 1'b1;
            state   <= ST_READ;
          end else begin
            dc    <= 1'b1;
            kind  <= TX_PAR;
            rate  <= longBurst ? RATE_FAST : RATE_CMD;
            load  <= 1'b1;
            state <= ST_WRITE;
          end
        end
        ST_WRITE: if (byteDone) begin
          remaining <= remaining - 1'b1;
          if (remaining == (CNT_W+1)'(1)) state <= ST_FINISH;
          else load <= 1'b1;
        end
        ST_READ: if (byteDone) begin
          remaining <= remaining - 1'b1;
          firstRx   <= 1'b0;
          prevRx    <= rxByte;
          if (!isDummy) begin
            rdValid <= 1'b1;
            rdData  <= rxByte;
            if (cmdReg == 8'h0A && firstRx)
              panelOn <= ((rxByte & 8'h7C) == 8'h1C);
          end else if (!firstRx) begin
            rdValid <= 1'b1;
            rdData  <= {prevRx[6:0], rxByte[7]};
          end
          if (remaining == (CNT_W+1)'(1)) state <= ST_FINISH;
          else load <= 1'b1;
        end
        default: begin
          csN   <= 1'b1;
          dc    <= 1'b0;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R2
  take_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    parTake |-> dc && !csN);
  // R5
  rd_in_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> busy && !dc);
  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !busy && csN);

endmodule

// File: rtl/dspi_engine.sv
module dspi_engine
  import dspi_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int LONG_MIN  = 4,
  parameter int FAST_HALF = 1,
  parameter int CMD_HALF  = 2,
  parameter int READ_HALF = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [7:0]       reqCmd,
  input  logic [CNT_W-1:0] reqLen,
  input  logic [7:0]       parData,
  output logic             parTake,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             rdValid,
  output logic [7:0]       rdData,
  output logic             panelOn,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             csN,
  output logic             dc
);
  dspi_strobe_t strb;
  logic [7:0]   txByte;
  logic [7:0]   rxByte;
  logic         byteDone;

  dspi_ctrl #(.CNT_W(CNT_W), .LONG_MIN(LONG_MIN)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCmd(reqCmd),
    .reqLen(reqLen), .parData(parData), .byteDone(byteDone),
    .rxByte(rxByte), .strb(strb), .txByte(txByte), .parTake(parTake),
    .csN(csN), .dc(dc), .busy(busy), .done(done), .err(err),
    .rdValid(rdValid), .rdData(rdData), .panelOn(panelOn)
  );

  dspi_shifter #(.FAST_HALF(FAST_HALF), .CMD_HALF(CMD_HALF),
                 .READ_HALF(READ_HALF)) uShift (
    .clk(clk), .rstN(rstN), .strb(strb), .txByte(txByte), .miso(miso),
    .sclk(sclk), .mosi(mosi), .byteDone(byteDone), .rxByte(rxByte)
  );

  // R3
  cs_during_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !csN);
  // R1
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> $stable(mosi));
  // R1
  dc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> $stable(dc));

endmodule

// File: tb/tb_dspi_engine.sv
module tb_dspi_engine;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  cmd;
    logic [7:0]  len;
    logic        rd;
    logic [47:0] wr;
    logic [63:0] resp;
    logic [31:0] rdx;
    logic        expErr;
    logic [15:0] expHigh;
    logic        chkPanel;
    logic        expPanel;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{8'h11, 8'd0, 1'b0, 48'h0, 64'h0, 32'h0, 1'b0, 16'd16, 1'b0, 1'b0},
    '{8'h2A, 8'd4, 1'b0, 48'hDEADBEEF_0000, 64'h0, 32'h0, 1'b0, 16'd80, 1'b0, 1'b0},
    '{8'h2C, 8'd6, 1'b0, 48'h0123456789AB, 64'h0, 32'h0, 1'b0, 16'd64, 1'b0, 1'b0},
    '{8'h0A, 8'd1, 1'b1, 48'h0, 64'h9C00_0000_0000_0000, 32'h9C000000, 1'b0, 16'd48, 1'b1, 1'b1},
    '{8'h0A, 8'd1, 1'b1, 48'h0, 64'h1800_0000_0000_0000, 32'h18000000, 1'b0, 16'd48, 1'b1, 1'b0},
    '{8'h04, 8'd3, 1'b1, 48'h0, 64'h8142C380_00000000, 32'h02858700, 1'b0, 16'd144, 1'b0, 1'b0},
    '{8'h09, 8'd4, 1'b1, 48'h0, 64'h7FFF0080_01000000, 32'hFFFE0100, 1'b0, 16'd176, 1'b0, 1'b0},
    '{8'h04, 8'd2, 1'b1, 48'h0, 64'h0, 32'h0, 1'b1, 16'd0, 1'b0, 1'b0},
    '{8'h09, 8'd5, 1'b1, 48'h0, 64'h0, 32'h0, 1'b1, 16'd0, 1'b0, 1'b0},
    '{8'h0C, 8'd2, 1'b1, 48'h0, 64'h55AA0000_00000000, 32'h55AA0000, 1'b0, 16'd80, 1'b0, 1'b0},
    '{8'h2B, 8'd5, 1'b0, 48'hA0A1A2A3A4_00, 64'h0, 32'h0, 1'b0, 16'd56, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [7:0] reqCmd = '0;
  logic [7:0] reqLen = '0;
  logic [7:0] parData;
  logic       parTake, busy, done, err, rdValid, panelOn, sclk, mosi, csN, dc;
  logic [7:0] rdData;
  logic       miso = 1'b0;

  dspi_engine dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCmd(reqCmd),
    .reqLen(reqLen), .parData(parData), .parTake(parTake), .busy(busy),
    .done(done), .err(err), .rdValid(rdValid), .rdData(rdData),
    .panelOn(panelOn), .sclk(sclk), .mosi(mosi), .miso(miso),
    .csN(csN), .dc(dc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0]  parArr [8];
  logic [2:0]  parIdx = '0;
  logic [63:0] curResp = '0;
  assign parData = parArr[parIdx];

  logic [7:0] logBytes [16];
  logic       logDc [16];
  logic [7:0] rdBuf [8];
  int nLog = 0, highCnt = 0, csFalls = 0, csNoBusy = 0, nRd = 0, takeCnt = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // serial monitor and reply model
  initial begin
    logic prevSclk = 1'b0, prevCs = 1'b1;
    logic [7:0] acc = '0;
    int bitN = 0, fallN = 0;
    forever begin
      @(negedge clk);
      if (reqValid && !busy) begin
        nLog = 0; highCnt = 0; csFalls = 0; csNoBusy = 0; nRd = 0; bitN = 0;
      end
      if (sclk) highCnt++;
      if (!csN && !busy) csNoBusy++;
      if (prevCs && !csN) begin csFalls++; fallN = 0; miso = 1'b0; end
      if (sclk && !prevSclk) begin
        acc = {acc[6:0], mosi};
        bitN++;
        if (bitN == 8) begin
          if (nLog < 16) begin logBytes[nLog] = acc; logDc[nLog] = dc; end
          nLog++; bitN = 0;
        end
      end
      if (!sclk && prevSclk) begin
        fallN++;
        miso = (fallN >= 8 && fallN < 72) ? curResp[71 - fallN] : 1'b0;
      end
      if (rdValid) begin
        if (nRd < 8) rdBuf[nRd] = rdData;
        nRd++;
      end
      prevSclk = sclk; prevCs = csN;
    end
  end

  // parameter feed
  initial begin
    forever begin
      bit took;
      @(negedge clk);
      if (reqValid && !busy) begin parIdx = '0; takeCnt = 0; end
      took = parTake;
      if (took) takeCnt++;
      @(posedge clk);
      #1;
      if (took) parIdx = parIdx + 3'd1;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "R3", "watchdog expired", 0, 1);
    finish();
  end

  task automatic issue(input logic [7:0] c, input logic [7:0] l);
    @(posedge clk); #1;
    reqCmd = c; reqLen = l; reqValid = 1'b1;
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic waitDone(output bit got);
    got = 0;
    for (int t = 0; t < 5000 && !got; t++) begin
      @(negedge clk);
      got = done;
    end
    @(negedge clk);
  endtask

  initial begin
    bit got;
    for (int i = 0; i < 8; i++) parArr[i] = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(csN === 1'b1 && sclk === 1'b0 && dc === 1'b0, "R10", "pins at reset",
          {csN, sclk, dc}, 3'b100);
    check(busy === 1'b0 && done === 1'b0 && err === 1'b0 && panelOn === 1'b0,
          "R10", "status at reset", {busy, done, err, panelOn}, 0);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      vec_t cv = VEC[v];
      int nClk, dummy;
      for (int i = 0; i < 6; i++) parArr[i] = cv.wr[47 - 8*i -: 8];
      curResp = cv.resp;
      dummy = (cv.cmd == 8'h04 || cv.cmd == 8'h09) ? 1 : 0;
      nClk = cv.expErr ? 0 : 1 + int'(cv.len) + dummy;
      issue(cv.cmd, cv.len);
      waitDone(got);
      check(got, "R3", "done pulse seen", got, 1);
      check(err == cv.expErr, "R7", "err flag", err, cv.expErr);
      check(nLog == nClk, cv.len == 0 ? "R9" : "R6", "bytes clocked", nLog, nClk);
      check(highCnt == int'(cv.expHigh), cv.rd ? "R5" : "R4", "sclk high cycles",
            highCnt, cv.expHigh);
      check(csNoBusy == 0, "R3", "cs low while not busy", csNoBusy, 0);
      check(csN == 1'b1 && busy == 1'b0, "R3", "released after done", {csN, busy}, 2'b10);
      if (cv.expErr) begin
        check(csFalls == 0, "R7", "cs never asserted", csFalls, 0);
      end else begin
        check(logBytes[0] == cv.cmd && logDc[0] == 1'b0, "R1", "command byte",
              {logDc[0], logBytes[0]}, {1'b0, cv.cmd});
        check(csFalls == 1, "R3", "single cs window", csFalls, 1);
        for (int b = 1; b < nClk && b < 16; b++) begin
          logic [7:0] eb = cv.rd ? 8'h00 : cv.wr[47 - 8*(b-1) -: 8];
          check(logBytes[b] == eb && logDc[b] == !cv.rd, cv.rd ? "R5" : "R2",
                "mosi byte and dc", {logDc[b], logBytes[b]}, {!cv.rd, eb});
        end
        if (cv.rd) begin
          check(nRd == int'(cv.len), "R5", "reply count", nRd, cv.len);
          for (int b = 0; b < int'(cv.len) && b < 4; b++)
            check(rdBuf[b] == cv.rdx[31 - 8*b -: 8], dummy ? "R6" : "R5",
                  "reply byte", rdBuf[b], cv.rdx[31 - 8*b -: 8]);
        end else begin
          check(takeCnt == int'(cv.len), "R2", "parTake pulses", takeCnt, cv.len);
        end
        if (cv.chkPanel)
          check(panelOn == cv.expPanel, "R8", "panel state", panelOn, cv.expPanel);
      end
    end

    // R8: a non-power-mode read leaves the panel state alone
    check(panelOn == 1'b0, "R8", "panel held after other reads", panelOn, 0);

    // R11: second request during a transfer is ignored
    parArr[0] = 8'h11; parArr[1] = 8'h22;
    curResp = '0;
    issue(8'h2A, 8'd2);
    repeat (20) @(negedge clk);
    issue(8'h0A, 8'd1);
    waitDone(got);
    check(got, "R11", "first transfer completes", got, 1);
    check(nLog == 3, "R11", "byte count unchanged", nLog, 3);
    check(logBytes[0] == 8'h2A && logBytes[1] == 8'h11 && logBytes[2] == 8'h22,
          "R11", "bytes unchanged", {logBytes[0], logBytes[1], logBytes[2]}, 24'h2A1122);
    repeat (5) @(negedge clk);
    check(busy == 1'b0 && csN == 1'b1, "R11", "no second transfer", {busy, csN}, 2'b01);

    finish();
  end
endmodule